// File: doc/BRIEF.md
# Stream FIFO with Occupancy Interrupt

This block buffers words that arrive on an AXI4-Stream slave port and lets a processor drain them through a small AXI4-Lite register port. It keeps its own occupancy count. The count goes up on every cycle in which the stream handshake completes, and it goes down on every read of the data register. Back-to-back transfers are therefore counted one by one, even when TVALID and TREADY both stay high.

Software sets a threshold while the block runs. A level interrupt then tells the processor that enough words are waiting, so it does not have to poll. The interrupt drops as soon as the processor pops the FIFO below the threshold. It also drops when software raises the threshold or clears the enable.

The register port takes one transfer at a time, with no bursts and no response-code signals. The register at byte offset 0x0 is status, 0x4 pops data, 0x8 holds the threshold and 0xC is control. The decode uses address bits [3:2].

Top module: `stream_occ_fifo`

## Requirements
- R1: After reset the occupancy is 0, s_tready is 1, irq is 0, the underflow flag is 0, and the threshold and control registers both read 0.
- R2: Each rising edge with s_tvalid and s_tready both high stores one word and adds one to the occupancy. This holds on consecutive cycles too.
- R3: s_tready is low exactly when the occupancy equals DEPTH (16). A word offered while the FIFO is full is not stored, and the occupancy stays at 16.
- R4: A read of offset 0x0 returns the occupancy in bits [4:0], the current s_tready in bit 16, the sticky underflow flag in bit 17, and zero in all other bits.
- R5: A read of offset 0x4 on a non-empty FIFO returns the oldest stored word and removes it. Words come out in arrival order.
- R6: A stream push and a data-register pop in the same cycle leave the occupancy unchanged.
- R7: A read of offset 0x4 on an empty FIFO returns 0, leaves the occupancy at 0, and sets the underflow flag. The flag stays set until software writes 0xC with bit 1 set.
- R8: Offset 0x8 is a read/write threshold held in bits [4:0]. A new value takes effect on irq in the cycle after the write is accepted.
- R9: irq is high exactly when the enable bit (0xC bit 0) is 1, the threshold is nonzero, and the occupancy is at least the threshold. A threshold of 0 keeps irq low. irq falls right after the pop that takes the occupancy below the threshold.
- R10: Register handshake: s_axil_arready is the inverse of s_axil_rvalid, and s_axil_awready and s_axil_wready are the inverse of s_axil_bvalid. rvalid and rdata hold steady until rready is seen. bvalid holds until bready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 32 | Stream data |
| s_tvalid | input | 1 | Stream valid |
| s_tready | output | 1 | Stream ready, low when full |
| s_axil_awaddr | input | 4 | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | 4 | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| irq | output | 1 | Level interrupt |

## Verification
A wrong count shows up on the very next status read. It also flips irq within one cycle once the threshold lies near the true occupancy. A bad pointer shows up on the first data read after it goes wrong, as a word that is out of order or repeated. Filling the FIFO to 16, pushing into it while full, and draining it back past empty exposes errors at both boundaries within a few dozen cycles.

// File: rtl/stream_occ_fifo.sv
module stream_occ_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [3:0]        s_axil_awaddr,
  input  logic              s_axil_awvalid,
  output logic              s_axil_awready,
  input  logic [DATA_W-1:0] s_axil_wdata,
  input  logic              s_axil_wvalid,
  output logic              s_axil_wready,
  output logic              s_axil_bvalid,
  input  logic              s_axil_bready,
  input  logic [3:0]        s_axil_araddr,
  input  logic              s_axil_arvalid,
  output logic              s_axil_arready,
  output logic [DATA_W-1:0] s_axil_rdata,
  output logic              s_axil_rvalid,
  input  logic              s_axil_rready,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam logic [1:0] A_STAT = 2'd0, A_DATA = 2'd1, A_THR = 2'd2, A_CTRL = 2'd3;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wptr, rptr;
  logic [CW-1:0]     count, thr;
  logic              irq_en, underflow;
  logic [DATA_W-1:0] stat_word;

  wire rd_go   = s_axil_arvalid && !s_axil_rvalid;
  wire wr_go   = s_axil_awvalid && s_axil_wvalid && !s_axil_bvalid;
  wire rd_data = rd_go && (s_axil_araddr[3:2] == A_DATA);
  wire empty   = (count == '0);
  wire push    = s_tvalid && s_tready;
  wire pop     = rd_data && !empty;

  assign s_tready       = (count != CW'(DEPTH));
  assign s_axil_arready = !s_axil_rvalid;
  assign s_axil_awready = !s_axil_bvalid;
  assign s_axil_wready  = !s_axil_bvalid;
  assign irq            = irq_en && (thr != '0) && (count >= thr);

  always_ff @(posedge clk)
    if (push) mem[wptr] <= s_tdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    stat_word            = '0;
    stat_word[CW-1:0]    = count;
    stat_word[16]        = s_tready;
    stat_word[17]        = underflow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr           <= '0;
      irq_en        <= 1'b0;
      underflow     <= 1'b0;
      s_axil_bvalid <= 1'b0;
      s_axil_rvalid <= 1'b0;
      s_axil_rdata  <= '0;
    end else begin
      if (wr_go) begin
        s_axil_bvalid <= 1'b1;
        if (s_axil_awaddr[3:2] == A_THR) thr <= s_axil_wdata[CW-1:0];
        if (s_axil_awaddr[3:2] == A_CTRL) begin
          irq_en <= s_axil_wdata[0];
          if (s_axil_wdata[1]) underflow <= 1'b0;
        end
      end else if (s_axil_bready) begin
        s_axil_bvalid <= 1'b0;
      end

      if (rd_data && empty) underflow <= 1'b1;

      if (rd_go) begin
        s_axil_rvalid <= 1'b1;
        case (s_axil_araddr[3:2])
          A_STAT:  s_axil_rdata <= stat_word;
          A_DATA:  s_axil_rdata <= empty ? '0 : mem[rptr];
          A_THR:   s_axil_rdata <= DATA_W'(thr);
          default: s_axil_rdata <= DATA_W'(irq_en);
        endcase
      end else if (s_axil_rready) begin
        s_axil_rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stream_occ_fifo_chk.sv
module stream_occ_fifo_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push,
  input logic              pop,
  input logic              rd_data,
  input logic [CW-1:0]     count,
  input logic              underflow,
  input logic              irq,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) && !pop |=> count == CW'(DEPTH)); // R3
  AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |=> count == CW'($past(count) + 1'b1)); // R2
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push |=> count == CW'($past(count) - 1'b1)); // R5
  AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop |=> $stable(count)); // R6
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && (count == '0) |=> (rdata == '0) && underflow); // R7
  AST_IRQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> count != '0); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata)); // R10
endmodule

bind stream_occ_fifo stream_occ_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .rd_data(rd_data),
  .count(count), .underflow(underflow), .irq(irq),
  .rvalid(s_axil_rvalid), .rready(s_axil_rready), .rdata(s_axil_rdata)
);

// File: tb/stream_occ_fifo_tb.sv
module stream_occ_fifo_tb;
  logic clk = 0, rst_n = 0;
  logic [31:0] s_tdata = '0;
  logic s_tvalid = 0, s_tready;
  logic [3:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, awready, wvalid = 0, wready, bvalid, bready = 0;
  logic [31:0] wdata = '0, rdata;
  logic arvalid = 0, arready, rvalid, rready = 0, irq;
  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  stream_occ_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
    .s_axil_wdata(wdata), .s_axil_wvalid(wvalid), .s_axil_wready(wready),
    .s_axil_bvalid(bvalid), .s_axil_bready(bready),
    .s_axil_araddr(araddr), .s_axil_arvalid(arvalid), .s_axil_arready(arready),
    .s_axil_rdata(rdata), .s_axil_rvalid(rvalid), .s_axil_rready(rready), .irq(irq));

  typedef struct packed { logic [1:0] op; logic [3:0] addr; logic [31:0] val; } vec_t;
  localparam logic [1:0] OP_PUSH = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,   4'h0, 32'h0001_0000},  // R1 R4 reset status
    '{OP_RD,   4'h8, 32'h0000_0000},  // R1 threshold
    '{OP_RD,   4'hC, 32'h0000_0000},  // R1 control
    '{OP_PUSH, 4'h0, 32'hA1A1_0001},  // R2
    '{OP_PUSH, 4'h0, 32'hA1A1_0002},
    '{OP_PUSH, 4'h0, 32'hA1A1_0003},
    '{OP_RD,   4'h0, 32'h0001_0003},  // R2 R4 count 3
    '{OP_RD,   4'h4, 32'hA1A1_0001},  // R5 oldest first
    '{OP_RD,   4'h4, 32'hA1A1_0002},  // R5
    '{OP_RD,   4'h0, 32'h0001_0001},  // R5 count down
    '{OP_RD,   4'h4, 32'hA1A1_0003},  // R5
    '{OP_RD,   4'h4, 32'h0000_0000},  // R7 empty read
    '{OP_RD,   4'h0, 32'h0003_0000},  // R7 sticky underflow
    '{OP_RD,   4'h0, 32'h0003_0000},  // R7 still set
    '{OP_WR,   4'hC, 32'h0000_0002},  // R7 clear
    '{OP_RD,   4'h0, 32'h0001_0000},  // R7 cleared
    '{OP_WR,   4'h8, 32'h0000_0003}   // R8 threshold 3
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] d);
    @(negedge clk); s_tvalid = 1; s_tdata = d;
    @(negedge clk); s_tvalid = 0;
  endtask

  task automatic reg_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); awvalid = 1; wvalid = 1; awaddr = a; wdata = d;
    @(negedge clk); awvalid = 0; wvalid = 0; bready = 1;
    @(negedge clk); bready = 0;
  endtask

  task automatic reg_rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); arvalid = 1; araddr = a;
    @(negedge clk); arvalid = 0; d = rdata; rready = 1;
    @(negedge clk); rready = 0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 50000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<50000", cycles);
        summary();
      end
    end
  end

  initial begin
    logic [31:0] r, held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 tready", 32'(s_tready), 1);
    check("R1 irq", 32'(irq), 0);
    check("R10 arready", 32'(arready), 1);
    check("R10 awready", 32'(awready & wready), 1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_PUSH: push(VEC[i].val);
        OP_WR:   reg_wr(VEC[i].addr, VEC[i].val);
        default: begin
          reg_rd(VEC[i].addr, r);
          check($sformatf("vector %0d", i), r, VEC[i].val);
        end
      endcase
    end

    reg_rd(4'h8, r); check("R8 threshold readback", r, 32'd3);
    reg_wr(4'hC, 32'h1);
    push(32'h11); push(32'h12);
    check("R9 below threshold", 32'(irq), 0);
    push(32'h13);
    check("R9 reach threshold", 32'(irq), 1);
    reg_wr(4'h8, 32'd4);
    check("R8 raise threshold", 32'(irq), 0);
    reg_wr(4'h8, 32'd2);
    check("R8 lower threshold", 32'(irq), 1);
    reg_rd(4'h4, r); check("R5 pop", r, 32'h11);
    check("R9 at threshold", 32'(irq), 1);
    @(negedge clk); arvalid = 1; araddr = 4'h4;
    @(negedge clk); arvalid = 0;
    check("R9 drop after pop", 32'(irq), 0);
    check("R5 pop data", rdata, 32'h12); rready = 1;
    @(negedge clk); rready = 0;
    reg_wr(4'h8, 32'd0);
    check("R9 zero threshold nonempty", 32'(irq), 0);
    reg_wr(4'h8, 32'd1);
    check("R9 threshold 1", 32'(irq), 1);
    reg_wr(4'hC, 32'h0);
    check("R9 enable cleared", 32'(irq), 0);
    reg_rd(4'h4, r); check("R5 pop last", r, 32'h13);
    reg_wr(4'h8, 32'd0); reg_wr(4'hC, 32'h1);
    check("R9 zero threshold empty", 32'(irq), 0);
    reg_wr(4'hC, 32'h0);

    for (int i = 0; i < 16; i++) begin
      check("R3 ready before full", 32'(s_tready), 1);
      push(32'h100 + 32'(i));
    end
    check("R3 ready low at full", 32'(s_tready), 0);
    @(negedge clk); s_tvalid = 1; s_tdata = 32'hDEAD;
    repeat (3) @(negedge clk);
    s_tvalid = 0;
    reg_rd(4'h0, r); check("R3 R4 full status", r, 32'h0000_0010);
    for (int i = 0; i < 16; i++) begin
      reg_rd(4'h4, r); check("R5 drain order", r, 32'h100 + 32'(i));
    end
    reg_rd(4'h0, r); check("R3 empty after drain", r, 32'h0001_0000);

    @(negedge clk); s_tvalid = 1;
    for (int i = 0; i < 4; i++) begin
      s_tdata = 32'h50 + 32'(i);
      @(negedge clk);
    end
    s_tvalid = 0;
    reg_rd(4'h0, r); check("R2 back-to-back count", r, 32'h0001_0004);

    @(negedge clk); s_tvalid = 1; s_tdata = 32'h77; arvalid = 1; araddr = 4'h4;
    @(negedge clk); s_tvalid = 0; arvalid = 0;
    check("R6 pop data", rdata, 32'h50); rready = 1;
    @(negedge clk); rready = 0;
    reg_rd(4'h0, r); check("R6 count unchanged", r, 32'h0001_0004);

    @(negedge clk); arvalid = 1; araddr = 4'h4;
    @(negedge clk); arvalid = 0; held = rdata;
    check("R10 arready low while pending", 32'(arready), 0);
    repeat (3) @(negedge clk);
    check("R10 rvalid held", 32'(rvalid), 1);
    check("R10 rdata held", rdata, held);
    check("R5 data", held, 32'h51);
    rready = 1; @(negedge clk); rready = 0;
    check("R10 rvalid cleared", 32'(rvalid), 0);
    @(negedge clk); awvalid = 1; wvalid = 1; awaddr = 4'h8; wdata = 32'd9;
    @(negedge clk); awvalid = 0; wvalid = 0;
    repeat (2) @(negedge clk);
    check("R10 bvalid held", 32'(bvalid), 1);
    bready = 1; @(negedge clk); bready = 0;
    check("R10 bvalid cleared", 32'(bvalid), 0);
    reg_rd(4'h4, r); check("R5 data", r, 32'h52);
    reg_rd(4'h4, r); check("R5 data", r, 32'h53);
    reg_rd(4'h4, r); check("R6 pushed word kept", r, 32'h77);

    summary();
  end
endmodule